// File: doc/BRIEF.md
# Paged Framebuffer Scan-Out

This block turns a page-organised monochrome framebuffer into a raster pixel stream. The RAM is 132 columns wide and 8 pages tall, and every byte holds eight vertically stacked pixels, least significant bit on top. A 96-by-16 window of that memory is read out, magnified four times in both directions, and delivered as a 384-by-64 stream. Each output pixel carries a valid flag, its output coordinates, and markers for the first and last pixel of the frame.

Scan-out happens only on demand. A one-cycle pulse on `redraw_req` arms a pending flag, and the next frame begins as soon as the sequencer is idle or finishing a frame. The vertical start line, the inverse flag and the force-all-lit flag are captured when the frame begins and stay fixed until it ends. A request that arrives during a frame is kept and starts one more frame directly after the current one.

The framebuffer RAM is external and has one cycle of read latency. The block issues one read per output pixel, so the stream runs without gaps from the first pixel of a frame to its last.

Top module: `page_scanout`

## Requirements
- R1: While `rst_n` is low and directly after its release, `pix_valid`, `frame_start`, `frame_end` and `ram_rd_en` are 0.
- R2: Output column x shows a bit of the RAM byte at column (x/4)+36; the RAM address is page*132 + column.
- R3: Output row y uses source line L = ((y/4) + start_line) mod 64, read from page L>>3 at bit L&7 (bit 0 is the top pixel of a page).
- R4: With both flags clear, a set bit gives `pix`=1 and a clear bit gives `pix`=0.
- R5: With inverse set and force-all-lit clear, a set bit gives `pix`=0 and a clear bit gives `pix`=1.
- R6: With force-all-lit set, every pixel of the frame is 1, whatever the RAM holds and whatever the inverse flag is.
- R7: Each frame holds 384*64 valid pixels in raster order: x counts 0..383 within a row, then y steps by one, from 0 to 63.
- R8: No pixel is streamed unless a redraw request is pending; with no request the block stays idle.
- R9: Each request produces exactly one frame. A request that arrives during a frame starts a second frame whose first pixel follows the first frame's last pixel in the next cycle.
- R10: Start line, inverse and force-all-lit are sampled when a frame starts; later changes to them affect only later frames.
- R11: `frame_start` is high exactly with pixel (0,0) and `frame_end` exactly with pixel (383,63).
- R12: Within a frame `pix_valid` stays high on every cycle from the first pixel to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_line | input | 6 | Vertical scroll offset in source lines |
| inverse_i | input | 1 | Invert pixel polarity |
| all_on_i | input | 1 | Force every pixel lit |
| redraw_req | input | 1 | One-cycle pulse requesting a frame |
| ram_addr | output | 11 | Framebuffer read address (page*132 + column) |
| ram_rd_en | output | 1 | Framebuffer read strobe |
| ram_rdata | input | 8 | Read data, valid one cycle after the strobe |
| pix | output | 1 | Pixel value, 1 = lit |
| pix_valid | output | 1 | Pixel qualifier |
| pix_x | output | 9 | Output column 0..383 |
| pix_y | output | 6 | Output row 0..63 |
| frame_start | output | 1 | First pixel of a frame |
| frame_end | output | 1 | Last pixel of a frame |

## Verification
Two things can happen in the same cycle: the final address of one frame is issued while a pending request launches the next frame with newly sampled flags. The bench pulses a request partway through a frame and changes start line and both flags at the same moment. It then requires that the old frame finishes with its original settings, that `frame_start` comes in the cycle right after `frame_end`, and that the new frame uses the new settings. Every pixel of every frame is compared with a value the bench computes from a closed-form RAM pattern.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Per-frame rendering mode captured at frame start.
  typedef struct packed {
    logic inv;
    logic all_on;
  } mode_t;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int OUT_W = 384,
  parameter int OUT_H = 64,
  parameter int LINES = 64,
  parameter int XW    = $clog2(OUT_W),
  parameter int YW    = $clog2(OUT_H),
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] start_line,
  input  logic          inverse_i,
  input  logic          all_on_i,
  input  logic          redraw_req,
  output logic          busy_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          first_o,
  output logic          last_o,
  output logic [LW-1:0] sl_o,
  output mode_t         mode_o
);
  logic          busy_q, busy_d, pend_q, pend_d;
  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic [LW-1:0] sl_q, sl_d;
  mode_t         mode_q, mode_d;
  logic          x_end, y_end, last, start, cnt_en;

  always_comb begin
    x_end  = (x_q == XW'(OUT_W - 1));
    y_end  = (y_q == YW'(OUT_H - 1));
    last   = busy_q & x_end & y_end;
    start  = pend_q & (~busy_q | last);
    pend_d = redraw_req | (pend_q & ~start);
    busy_d = start | (busy_q & ~last);
    cnt_en = start | busy_q;
    x_d    = x_q;
    y_d    = y_q;
    sl_d   = sl_q;
    mode_d = mode_q;
    if (start) begin
      x_d    = '0;
      y_d    = '0;
      sl_d   = start_line;
      mode_d = '{inv: inverse_i, all_on: all_on_i};
    end else if (busy_q) begin
      if (x_end) begin
        x_d = '0;
        y_d = y_q + YW'(1);
      end else begin
        x_d = x_q + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (cnt_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_q   <= '0;
      mode_q <= '0;
    end else if (start) begin
      sl_q   <= sl_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o  = busy_q;
  assign x_o     = x_q;
  assign y_o     = y_q;
  assign first_o = busy_q & (x_q == '0) & (y_q == '0);
  assign last_o  = last;
  assign sl_o    = sl_q;
  assign mode_o  = mode_q;

  // R12
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !busy_q) |=> !busy_q);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !((x_q == '0) && (y_q == '0))) |-> $stable({sl_q, mode_q}));
endmodule

// File: rtl/scan_addr.sv
module scan_addr #(
  parameter int SCALE    = 4,
  parameter int RAM_COLS = 132,
  parameter int COL_OFS  = 36,
  parameter int BITS     = 8,
  parameter int XW       = 9,
  parameter int YW       = 6,
  parameter int LW       = 6,
  parameter int AW       = 11,
  parameter int BW       = $clog2(BITS)
) (
  input  logic          valid_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [LW-1:0] sl_i,
  output logic [AW-1:0] ram_addr,
  output logic          ram_rd_en,
  output logic [BW-1:0] bit_o
);
  logic [XW-1:0] src_col;
  logic [YW-1:0] src_row;
  logic [LW-1:0] line;
  int            page;

  always_comb begin
    src_col   = XW'(int'(x_i) / SCALE);
    src_row   = YW'(int'(y_i) / SCALE);
    // LINES is a power of two, so truncation performs the wrap.
    line      = LW'(src_row) + sl_i;
    page      = int'(line) / BITS;
    bit_o     = BW'(int'(line) % BITS);
    ram_addr  = AW'(page * RAM_COLS + COL_OFS + int'(src_col));
    ram_rd_en = valid_i;
  end
endmodule

// File: rtl/scan_pixel.sv
module scan_pixel
  import scan_pkg::*;
#(
  parameter int OUT_W = 384,
  parameter int OUT_H = 64,
  parameter int BITS  = 8,
  parameter int XW    = $clog2(OUT_W),
  parameter int YW    = $clog2(OUT_H),
  parameter int BW    = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_valid,
  input  logic [XW-1:0]   a_x,
  input  logic [YW-1:0]   a_y,
  input  logic            a_first,
  input  logic            a_last,
  input  logic [BW-1:0]   a_bit,
  input  mode_t           a_mode,
  input  logic [BITS-1:0] ram_rdata,
  output logic            pix_o,
  output logic            pix_valid_o,
  output logic [XW-1:0]   pix_x_o,
  output logic [YW-1:0]   pix_y_o,
  output logic            frame_start_o,
  output logic            frame_end_o
);
  logic          b_valid, b_first, b_last;
  logic [XW-1:0] b_x;
  logic [YW-1:0] b_y;
  logic [BW-1:0] b_bit;
  mode_t         b_mode;
  logic          pix_d;

  // Stage B: coordinates wait one cycle for the RAM data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_first <= 1'b0;
      b_last  <= 1'b0;
    end else begin
      b_valid <= a_valid;
      b_first <= a_valid & a_first;
      b_last  <= a_valid & a_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_x    <= '0;
      b_y    <= '0;
      b_bit  <= '0;
      b_mode <= '0;
    end else if (a_valid) begin
      b_x    <= a_x;
      b_y    <= a_y;
      b_bit  <= a_bit;
      b_mode <= a_mode;
    end
  end

  always_comb begin
    pix_d = b_mode.all_on | (ram_rdata[b_bit] ^ b_mode.inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o   <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
    end else begin
      pix_valid_o   <= b_valid;
      frame_start_o <= b_first;
      frame_end_o   <= b_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_o   <= 1'b0;
      pix_x_o <= '0;
      pix_y_o <= '0;
    end else if (b_valid) begin
      pix_o   <= pix_d;
      pix_x_o <= b_x;
      pix_y_o <= b_y;
    end
  end

  // R11
  fs_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (pix_valid_o && pix_x_o == '0 && pix_y_o == '0));

  // R11
  fe_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> (pix_valid_o && pix_x_o == XW'(OUT_W - 1) && pix_y_o == YW'(OUT_H - 1)));

  // R6
  allon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_mode.all_on) |=> pix_o);

  // R7
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && pix_x_o != XW'(OUT_W - 1)) |=>
      (pix_valid_o && pix_x_o == XW'($past(pix_x_o) + XW'(1))));
endmodule

// File: rtl/page_scanout.sv
module page_scanout
  import scan_pkg::*;
#(
  parameter int VIS_W    = 96,
  parameter int VIS_H    = 16,
  parameter int SCALE    = 4,
  parameter int RAM_COLS = 132,
  parameter int PAGES    = 8,
  parameter int COL_OFS  = 36,
  parameter int BITS     = 8,
  localparam int LINES   = PAGES * BITS,
  localparam int OUT_W   = VIS_W * SCALE,
  localparam int OUT_H   = VIS_H * SCALE,
  localparam int AW      = $clog2(RAM_COLS * PAGES),
  localparam int XW      = $clog2(OUT_W),
  localparam int YW      = $clog2(OUT_H),
  localparam int LW      = $clog2(LINES),
  localparam int BW      = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   start_line,
  input  logic            inverse_i,
  input  logic            all_on_i,
  input  logic            redraw_req,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_rd_en,
  input  logic [BITS-1:0] ram_rdata,
  output logic            pix,
  output logic            pix_valid,
  output logic [XW-1:0]   pix_x,
  output logic [YW-1:0]   pix_y,
  output logic            frame_start,
  output logic            frame_end
);
  logic          a_busy, a_first, a_last;
  logic [XW-1:0] a_x;
  logic [YW-1:0] a_y;
  logic [LW-1:0] a_sl;
  mode_t         a_mode;
  logic [BW-1:0] a_bit;

  scan_seq #(
    .OUT_W(OUT_W), .OUT_H(OUT_H), .LINES(LINES),
    .XW(XW), .YW(YW), .LW(LW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_line (start_line),
    .inverse_i  (inverse_i),
    .all_on_i   (all_on_i),
    .redraw_req (redraw_req),
    .busy_o     (a_busy),
    .x_o        (a_x),
    .y_o        (a_y),
    .first_o    (a_first),
    .last_o     (a_last),
    .sl_o       (a_sl),
    .mode_o     (a_mode)
  );

  scan_addr #(
    .SCALE(SCALE), .RAM_COLS(RAM_COLS), .COL_OFS(COL_OFS), .BITS(BITS),
    .XW(XW), .YW(YW), .LW(LW), .AW(AW), .BW(BW)
  ) u_addr (
    .valid_i   (a_busy),
    .x_i       (a_x),
    .y_i       (a_y),
    .sl_i      (a_sl),
    .ram_addr  (ram_addr),
    .ram_rd_en (ram_rd_en),
    .bit_o     (a_bit)
  );

  scan_pixel #(
    .OUT_W(OUT_W), .OUT_H(OUT_H), .BITS(BITS),
    .XW(XW), .YW(YW), .BW(BW)
  ) u_pix (
    .clk           (clk),
    .rst_n         (rst_n),
    .a_valid       (a_busy),
    .a_x           (a_x),
    .a_y           (a_y),
    .a_first       (a_first),
    .a_last        (a_last),
    .a_bit         (a_bit),
    .a_mode        (a_mode),
    .ram_rdata     (ram_rdata),
    .pix_o         (pix),
    .pix_valid_o   (pix_valid),
    .pix_x_o       (pix_x),
    .pix_y_o       (pix_y),
    .frame_start_o (frame_start),
    .frame_end_o   (frame_end)
  );
endmodule

// File: tb/page_scanout_bench.sv
module page_scanout_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  start_line;
  logic        inverse_i, all_on_i, redraw_req;
  logic [10:0] ram_addr;
  logic        ram_rd_en;
  logic [7:0]  ram_rdata;
  logic        pix, pix_valid, frame_start, frame_end;
  logic [8:0]  pix_x;
  logic [5:0]  pix_y;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int frame_cnt = 0;
  int ex = 0, ey = 0;
  bit in_frame = 0, expect_b2b = 0, mon_en = 0;
  int cfg_sl [4];
  bit cfg_inv[4];
  bit cfg_on [4];

  always #2 clk = ~clk;

  page_scanout u_page_scanout (
    .clk(clk), .rst_n(rst_n), .start_line(start_line),
    .inverse_i(inverse_i), .all_on_i(all_on_i), .redraw_req(redraw_req),
    .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_rdata(ram_rdata),
    .pix(pix), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  function automatic logic [7:0] pat(int a);
    int v;
    v = a * 29 + (a / 16) * 7 + 3;
    return v[7:0];
  endfunction

  // RAM model with one cycle of read latency.
  always @(posedge clk) if (ram_rd_en) ram_rdata <= pat(int'(ram_addr));

  function automatic bit exp_pix(int x, int y, int sl, bit inv, bit on);
    int line, addr;
    logic [7:0] b;
    line = ((y / 4) + sl) % 64;
    addr = (line / 8) * 132 + (x / 4) + 36;
    b = pat(addr);
    if (on) return 1'b1;
    return b[line % 8] ^ inv;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    if (pix_valid) begin
      if (frame_cnt < 4) begin
        chk(int'(pix_x) == ex, "R7 column order", int'(pix_x), ex);
        chk(int'(pix_y) == ey, "R7 row order", int'(pix_y), ey);
        chk(frame_start == (ex == 0 && ey == 0), "R11 frame_start", int'(frame_start), int'(ex == 0 && ey == 0));
        chk(frame_end == (ex == 383 && ey == 63), "R11 frame_end", int'(frame_end), int'(ex == 383 && ey == 63));
        chk(pix == exp_pix(ex, ey, cfg_sl[frame_cnt], cfg_inv[frame_cnt], cfg_on[frame_cnt]),
            "R2 R3 R4 R5 R6 R10 pixel", int'(pix),
            int'(exp_pix(ex, ey, cfg_sl[frame_cnt], cfg_inv[frame_cnt], cfg_on[frame_cnt])));
        if (expect_b2b) begin
          chk(frame_start == 1'b1, "R9 back-to-back start", int'(frame_start), 1);
          expect_b2b = 0;
        end
        if (ex == 383 && ey == 63) begin
          frame_cnt++;
          in_frame = 0;
          ex = 0;
          ey = 0;
          if (frame_cnt == 2) expect_b2b = 1;
        end else begin
          in_frame = 1;
          if (ex == 383) begin ex = 0; ey++; end
          else ex++;
        end
      end else begin
        chk(1'b0, "R8 unrequested pixel", 1, 0);
      end
    end else begin
      if (in_frame) chk(1'b0, "R12 gap in frame", 0, 1);
      if (expect_b2b) begin
        chk(1'b0, "R9 back-to-back start", 0, 1);
        expect_b2b = 0;
      end
    end
  end

  task automatic idle(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pix_valid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic pulse();
    @(negedge clk) redraw_req = 1'b1;
    @(negedge clk) redraw_req = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      chk(1'b0, "watchdog", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    cfg_sl[0] = 0;  cfg_inv[0] = 0; cfg_on[0] = 0;
    cfg_sl[1] = 57; cfg_inv[1] = 1; cfg_on[1] = 0;
    cfg_sl[2] = 13; cfg_inv[2] = 0; cfg_on[2] = 1;
    cfg_sl[3] = 63; cfg_inv[3] = 0; cfg_on[3] = 0;
    rst_n = 1'b0; start_line = '0; inverse_i = 0; all_on_i = 0; redraw_req = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk(!pix_valid && !frame_start && !frame_end && !ram_rd_en, "R1 reset outputs",
        int'({pix_valid, frame_start, frame_end, ram_rd_en}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_valid && !ram_rd_en, "R1 after release", int'({pix_valid, ram_rd_en}), 0);
    mon_en = 1;
    idle(20, "R8 idle without request");
    // Frame 0: plain polarity, no scroll
    start_line = 6'd0; inverse_i = 0; all_on_i = 0;
    pulse();
    while (frame_cnt < 1) @(negedge clk);
    idle(30, "R9 request consumed");
    // Frame 1: inverse with wrapping start line
    start_line = 6'd57; inverse_i = 1; all_on_i = 0;
    pulse();
    repeat (200) @(negedge clk);
    // Mid-frame request with new settings for frame 2
    start_line = 6'd13; inverse_i = 0; all_on_i = 1;
    pulse();
    while (frame_cnt < 3) @(negedge clk);
    idle(30, "R9 exactly one extra frame");
    // Frame 3: maximum start line
    start_line = 6'd63; inverse_i = 0; all_on_i = 0;
    pulse();
    while (frame_cnt < 4) @(negedge clk);
    idle(50, "R8 idle after last frame");
    finish_run();
  end
endmodule